// File: doc/BRIEF.md
# Branch and Exception Issue Sequencer

This block is the front-end control sequencer of an eight-stage in-order pipeline. The stages are three fetch stages, decode, three execute stages and writeback. An instruction class is presented at decode on a valid/ready handshake. Once a class is accepted, the sequencer produces its timing profile. It first holds decode for that class's extra issue cycles. It then flushes fetch for the branch-penalty cycles while the target is refetched from the first fetch stage. Finally it reports the cycle in which the target instruction reaches decode.

A prefetch-hit count gives the number of target fetch stages that are already filled. It shortens the penalty of the classes that allow this. The penalty is the class maximum minus the hit count, floored at zero. Exception return and trap follow long fixed sequences. Sleep ends in a clock-halt request that is held until a wake input arrives. Target address calculation, datapath execution and the clock gating itself are handled elsewhere.

Back-pressure rules: `id_ready` is high only while the sequencer is idle. A class transfers on a clock edge where `id_valid` and `id_ready` are both high. `id_valid` may stay high while `id_ready` is low. It has no effect until `id_ready` returns, and the class presented at that point is the one accepted.

Top module: `issue_seq`

## Requirements
- R1: A synchronous active-high reset, applied at any point, leaves the sequencer idle: `id_ready`=1, and `busy`, `id_hold`, `fetch_flush`, `redirect`, `tgt_enter` and `sleep_req` all 0.
- R2: A class is accepted only on an edge with `id_valid`=1 and `id_ready`=1. `id_ready` is 0 whenever `busy` is 1. A class presented while busy is not accepted and does not lengthen the running sequence.
- R3: Class codes: 0 and 7 are plain. A plain class is accepted with no hold, no flush, no redirect and no target strobe.
- R4: Class 1 (PC-relative branch) has 1 issue cycle and a penalty of 3 minus `pf_hits`, floored at 0.
- R5: Class 2 (register-indirect jump) has 1 issue cycle and a fixed penalty of 4 whatever `pf_hits` is.
- R6: Class 3 (subroutine return) has 1 issue cycle and a penalty of 4 minus `pf_hits`, floored at 0.
- R7: Class 4 (exception return) holds decode for 3 cycles after acceptance (4 issue cycles), then flushes for 2 cycles. `pf_hits` is ignored.
- R8: Class 5 (trap) holds decode for 12 cycles after acceptance (8 issue cycles plus 5 stall cycles), then flushes for 2 cycles. `tgt_enter` pulses in cycle 15 after acceptance.
- R9: Class 6 (sleep) holds decode for 1 cycle and raises `sleep_req` in cycle 2. `sleep_req` stays high until `wake`=1 is sampled; on the next cycle the sequencer is idle.
- R10: `wake` has no effect while `sleep_req` is 0.
- R11: For a branching class with H hold cycles and penalty P, `id_hold` is high in cycles 1..H after acceptance and `fetch_flush` in cycles H+1..H+P. `redirect` pulses in cycle H+1 and `tgt_enter` pulses in cycle H+P+1. The sequencer is idle again in cycle H+P+1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| id_valid | input | 1 | Class valid at decode |
| id_ready | output | 1 | Sequencer idle, class can be taken |
| id_class | input | 3 | Instruction class code |
| pf_hits | input | HIT_W (2) | Count of already fetched target stages |
| wake | input | 1 | Leave the sleep state |
| id_hold | output | 1 | Hold decode for extra issue cycles |
| fetch_flush | output | 1 | Flush or block fetch during the penalty |
| redirect | output | 1 | One-cycle pulse steering fetch to the target |
| tgt_enter | output | 1 | One-cycle pulse: target instruction in decode |
| sleep_req | output | 1 | Clock-halt request |
| busy | output | 1 | A sequence is in progress |

## Verification
The bench builds the block with its default parameters. These are the per-class issue and penalty counts listed above, with a 2-bit hit count. The hit count therefore covers zero, partial and full reduction, including the floor at zero for the branch class and a residual one-cycle penalty for return. The defaults also bring the longest sequence, the 15-cycle trap, within reach. This allows wake and new requests to be injected in its middle. Back-pressure is exercised by keeping a request valid across a whole jump sequence, and reset is exercised halfway through a trap.

// File: rtl/isq_pkg.sv
package isq_pkg;

  typedef enum logic [2:0] {
    CLS_PLAIN  = 3'd0,
    CLS_BRREL  = 3'd1,
    CLS_JIND   = 3'd2,
    CLS_RET    = 3'd3,
    CLS_XRET   = 3'd4,
    CLS_TRAP   = 3'd5,
    CLS_SLEEP  = 3'd6,
    CLS_PLAIN2 = 3'd7
  } iclass_e;

  typedef enum logic [1:0] {
    PH_IDLE  = 2'd0,
    PH_HOLD  = 2'd1,
    PH_PEN   = 2'd2,
    PH_SLEEP = 2'd3
  } phase_e;

endpackage

// File: rtl/isq_profile.sv
module isq_profile
  import isq_pkg::*;
#(
  parameter int CNT_W      = 4,
  parameter int BR_ISSUE   = 1,
  parameter int BR_PEN     = 3,
  parameter int JMP_ISSUE  = 1,
  parameter int JMP_PEN    = 4,
  parameter int RET_ISSUE  = 1,
  parameter int RET_PEN    = 4,
  parameter int XRET_ISSUE = 4,
  parameter int XRET_PEN   = 2,
  parameter int TRAP_ISSUE = 8,
  parameter int TRAP_STALL = 5,
  parameter int TRAP_PEN   = 2,
  parameter int SLP_ISSUE  = 2
) (
  input  logic [2:0]       cls,
  output logic [CNT_W-1:0] hold_cyc,
  output logic [CNT_W-1:0] pen_max,
  output logic             reducible,
  output logic             branching,
  output logic             sleeping
);

  always_comb begin
    hold_cyc  = '0;
    pen_max   = '0;
    reducible = 1'b0;
    branching = 1'b0;
    sleeping  = 1'b0;
    case (iclass_e'(cls))
      CLS_BRREL: begin
        hold_cyc  = CNT_W'(BR_ISSUE - 1);
        pen_max   = CNT_W'(BR_PEN);
        reducible = 1'b1;
        branching = 1'b1;
      end
      CLS_JIND: begin
        hold_cyc  = CNT_W'(JMP_ISSUE - 1);
        pen_max   = CNT_W'(JMP_PEN);
        branching = 1'b1;
      end
      CLS_RET: begin
        hold_cyc  = CNT_W'(RET_ISSUE - 1);
        pen_max   = CNT_W'(RET_PEN);
        reducible = 1'b1;
        branching = 1'b1;
      end
      CLS_XRET: begin
        hold_cyc  = CNT_W'(XRET_ISSUE - 1);
        pen_max   = CNT_W'(XRET_PEN);
        branching = 1'b1;
      end
      CLS_TRAP: begin
        hold_cyc  = CNT_W'(TRAP_ISSUE - 1 + TRAP_STALL);
        pen_max   = CNT_W'(TRAP_PEN);
        branching = 1'b1;
      end
      CLS_SLEEP: begin
        hold_cyc = CNT_W'(SLP_ISSUE - 1);
        sleeping = 1'b1;
      end
      default: ;
    endcase
  end

endmodule

// File: rtl/isq_penalty.sv
module isq_penalty #(
  parameter int CNT_W = 4,
  parameter int HIT_W = 2
) (
  input  logic [CNT_W-1:0] pen_max,
  input  logic [HIT_W-1:0] hits,
  input  logic             reducible,
  output logic [CNT_W-1:0] pen
);

  localparam int PAD = CNT_W - HIT_W;

  logic [CNT_W-1:0] hits_w;

  generate
    if (PAD > 0) begin : g_pad
      assign hits_w = {{PAD{1'b0}}, hits};
    end else begin : g_nopad
      assign hits_w = hits[CNT_W-1:0];
    end
  endgenerate

  always_comb begin
    if (!reducible)
      pen = pen_max;
    else if (pen_max > hits_w)
      pen = pen_max - hits_w;
    else
      pen = '0;
  end

endmodule

// File: rtl/isq_count.sv
module isq_count #(
  parameter int CNT_W = 4
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             load,
  input  logic [CNT_W-1:0] load_val,
  output logic             last
);

  logic [CNT_W-1:0] cnt_q;

  always_ff @(posedge clk) begin
    if (rst)
      cnt_q <= '0;
    else if (load)
      cnt_q <= load_val;
    else if (cnt_q != '0)
      cnt_q <= cnt_q - 1'b1;
  end

  assign last = (cnt_q == CNT_W'(1));

endmodule

// File: rtl/issue_seq.sv
module issue_seq
  import isq_pkg::*;
#(
  parameter int HIT_W      = 2,
  parameter int BR_ISSUE   = 1,
  parameter int BR_PEN     = 3,
  parameter int JMP_ISSUE  = 1,
  parameter int JMP_PEN    = 4,
  parameter int RET_ISSUE  = 1,
  parameter int RET_PEN    = 4,
  parameter int XRET_ISSUE = 4,
  parameter int XRET_PEN   = 2,
  parameter int TRAP_ISSUE = 8,
  parameter int TRAP_STALL = 5,
  parameter int TRAP_PEN   = 2,
  parameter int SLP_ISSUE  = 2
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             id_valid,
  output logic             id_ready,
  input  logic [2:0]       id_class,
  input  logic [HIT_W-1:0] pf_hits,
  input  logic             wake,
  output logic             id_hold,
  output logic             fetch_flush,
  output logic             redirect,
  output logic             tgt_enter,
  output logic             sleep_req,
  output logic             busy
);

  localparam int TRAP_HOLD = TRAP_ISSUE - 1 + TRAP_STALL;
  localparam int M1   = (BR_PEN > JMP_PEN) ? BR_PEN : JMP_PEN;
  localparam int M2   = (RET_PEN > XRET_PEN) ? RET_PEN : XRET_PEN;
  localparam int M3   = (TRAP_HOLD > TRAP_PEN) ? TRAP_HOLD : TRAP_PEN;
  localparam int M4   = (M1 > M2) ? M1 : M2;
  localparam int M5   = (M3 > M4) ? M3 : M4;
  localparam int M6   = (XRET_ISSUE > SLP_ISSUE) ? XRET_ISSUE : SLP_ISSUE;
  localparam int MAXC = (M5 > M6) ? M5 : M6;
  localparam int CW0  = $clog2(MAXC + 1);
  localparam int CNT_W = (CW0 > HIT_W) ? CW0 : HIT_W;

  phase_e           phase_q, phase_n;
  logic [CNT_W-1:0] hold_cyc, pen_max, pen_calc;
  logic             reducible, branching, sleeping;
  logic [CNT_W-1:0] pen_q, pen_n;
  logic             brn_q, brn_n, slp_q, slp_n;
  logic             redir_q, redir_n, tgt_q, tgt_n;
  logic             cnt_load, cnt_last;
  logic [CNT_W-1:0] cnt_val;
  logic             accept;

  logic [CNT_W-1:0] sel_pen;
  logic             sel_brn, sel_slp;

  isq_profile #(
    .CNT_W(CNT_W), .BR_ISSUE(BR_ISSUE), .BR_PEN(BR_PEN),
    .JMP_ISSUE(JMP_ISSUE), .JMP_PEN(JMP_PEN),
    .RET_ISSUE(RET_ISSUE), .RET_PEN(RET_PEN),
    .XRET_ISSUE(XRET_ISSUE), .XRET_PEN(XRET_PEN),
    .TRAP_ISSUE(TRAP_ISSUE), .TRAP_STALL(TRAP_STALL), .TRAP_PEN(TRAP_PEN),
    .SLP_ISSUE(SLP_ISSUE)
  ) u_prof (
    .cls       (id_class),
    .hold_cyc  (hold_cyc),
    .pen_max   (pen_max),
    .reducible (reducible),
    .branching (branching),
    .sleeping  (sleeping)
  );

  isq_penalty #(.CNT_W(CNT_W), .HIT_W(HIT_W)) u_pen (
    .pen_max   (pen_max),
    .hits      (pf_hits),
    .reducible (reducible),
    .pen       (pen_calc)
  );

  isq_count #(.CNT_W(CNT_W)) u_cnt (
    .clk      (clk),
    .rst      (rst),
    .load     (cnt_load),
    .load_val (cnt_val),
    .last     (cnt_last)
  );

  assign accept = id_valid && (phase_q == PH_IDLE);

  // Post-hold choice uses fresh profile on acceptance, stored one later
  assign sel_pen = (phase_q == PH_IDLE) ? pen_calc  : pen_q;
  assign sel_brn = (phase_q == PH_IDLE) ? branching : brn_q;
  assign sel_slp = (phase_q == PH_IDLE) ? sleeping  : slp_q;

  always_comb begin
    phase_n  = phase_q;
    pen_n    = pen_q;
    brn_n    = brn_q;
    slp_n    = slp_q;
    cnt_load = 1'b0;
    cnt_val  = '0;
    redir_n  = 1'b0;
    tgt_n    = 1'b0;
    case (phase_q)
      PH_IDLE: begin
        if (accept) begin
          pen_n = pen_calc;
          brn_n = branching;
          slp_n = sleeping;
          if (hold_cyc != '0) begin
            phase_n  = PH_HOLD;
            cnt_load = 1'b1;
            cnt_val  = hold_cyc;
          end
        end
      end
      PH_PEN: begin
        if (cnt_last) begin
          phase_n = PH_IDLE;
          tgt_n   = 1'b1;
        end
      end
      PH_SLEEP: begin
        if (wake)
          phase_n = PH_IDLE;
      end
      default: ;
    endcase

    // Leaving the issue phase: shared by zero-hold acceptance and hold end
    if ((accept && hold_cyc == '0) || (phase_q == PH_HOLD && cnt_last)) begin
      if (sel_slp) begin
        phase_n = PH_SLEEP;
      end else if (sel_pen != '0) begin
        phase_n  = PH_PEN;
        cnt_load = 1'b1;
        cnt_val  = sel_pen;
        redir_n  = sel_brn;
      end else begin
        phase_n = PH_IDLE;
        redir_n = sel_brn;
        tgt_n   = sel_brn;
      end
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      phase_q <= PH_IDLE;
      pen_q   <= '0;
      brn_q   <= 1'b0;
      slp_q   <= 1'b0;
      redir_q <= 1'b0;
      tgt_q   <= 1'b0;
    end else begin
      phase_q <= phase_n;
      pen_q   <= pen_n;
      brn_q   <= brn_n;
      slp_q   <= slp_n;
      redir_q <= redir_n;
      tgt_q   <= tgt_n;
    end
  end

  assign id_ready    = (phase_q == PH_IDLE);
  assign busy        = (phase_q != PH_IDLE);
  assign id_hold     = (phase_q == PH_HOLD);
  assign fetch_flush = (phase_q == PH_PEN);
  assign sleep_req   = (phase_q == PH_SLEEP);
  assign redirect    = redir_q;
  assign tgt_enter   = tgt_q;

endmodule

// File: rtl/isq_checks.sv
module isq_checks (
  input logic clk,
  input logic rst,
  input logic id_valid,
  input logic id_ready,
  input logic wake,
  input logic id_hold,
  input logic fetch_flush,
  input logic redirect,
  input logic tgt_enter,
  input logic sleep_req,
  input logic busy
);

  p_busy_blocks_r2: assert property (@(posedge clk) disable iff (rst)
    busy |-> !id_ready);

  p_flush_ends_in_target_r11: assert property (@(posedge clk) disable iff (rst)
    $fell(fetch_flush) |-> tgt_enter);

  p_target_source_r11: assert property (@(posedge clk) disable iff (rst)
    tgt_enter |-> ($past(fetch_flush) || $past(id_valid && id_ready)));

  p_redirect_single_r11: assert property (@(posedge clk) disable iff (rst)
    redirect |=> !redirect);

  p_sleep_kept_r9: assert property (@(posedge clk) disable iff (rst)
    (sleep_req && !wake) |=> sleep_req);

  p_wake_idles_r9: assert property (@(posedge clk) disable iff (rst)
    (sleep_req && wake) |=> (!busy && !sleep_req));

  p_wake_ignored_r10: assert property (@(posedge clk) disable iff (rst)
    (fetch_flush && wake) |=> !sleep_req);

endmodule

bind issue_seq isq_checks u_isq_checks (
  .clk         (clk),
  .rst         (rst),
  .id_valid    (id_valid),
  .id_ready    (id_ready),
  .wake        (wake),
  .id_hold     (id_hold),
  .fetch_flush (fetch_flush),
  .redirect    (redirect),
  .tgt_enter   (tgt_enter),
  .sleep_req   (sleep_req),
  .busy        (busy)
);

// File: tb/test_issue_seq.sv
module test_issue_seq;

  localparam int CLK_PERIOD = 10;
  localparam int WINDOW     = 20;

  typedef struct packed {
    logic [2:0] cls;
    logic [1:0] hits;
    logic [4:0] hold;
    logic [2:0] pen;
    logic       brn;
  } vec_t;

  localparam int NVEC = 14;
  localparam vec_t TBL [NVEC] = '{
    '{3'd1, 2'd0, 5'd0,  3'd3, 1'b1},
    '{3'd1, 2'd1, 5'd0,  3'd2, 1'b1},
    '{3'd1, 2'd3, 5'd0,  3'd0, 1'b1},
    '{3'd2, 2'd0, 5'd0,  3'd4, 1'b1},
    '{3'd2, 2'd3, 5'd0,  3'd4, 1'b1},
    '{3'd3, 2'd0, 5'd0,  3'd4, 1'b1},
    '{3'd3, 2'd2, 5'd0,  3'd2, 1'b1},
    '{3'd3, 2'd3, 5'd0,  3'd1, 1'b1},
    '{3'd4, 2'd0, 5'd3,  3'd2, 1'b1},
    '{3'd4, 2'd3, 5'd3,  3'd2, 1'b1},
    '{3'd5, 2'd0, 5'd12, 3'd2, 1'b1},
    '{3'd5, 2'd2, 5'd12, 3'd2, 1'b1},
    '{3'd0, 2'd0, 5'd0,  3'd0, 1'b0},
    '{3'd7, 2'd1, 5'd0,  3'd0, 1'b0}
  };

  logic       clk = 1'b0;
  logic       rst = 1'b1;
  logic       id_valid = 1'b0;
  logic [2:0] id_class = 3'd0;
  logic [1:0] pf_hits = 2'd0;
  logic       wake = 1'b0;
  logic       id_ready, id_hold, fetch_flush, redirect, tgt_enter, sleep_req, busy;

  int n_checks = 0;
  int n_fail   = 0;
  bit done     = 1'b0;

  issue_seq i_issue_seq (
    .clk         (clk),
    .rst         (rst),
    .id_valid    (id_valid),
    .id_ready    (id_ready),
    .id_class    (id_class),
    .pf_hits     (pf_hits),
    .wake        (wake),
    .id_hold     (id_hold),
    .fetch_flush (fetch_flush),
    .redirect    (redirect),
    .tgt_enter   (tgt_enter),
    .sleep_req   (sleep_req),
    .busy        (busy)
  );

  always #(CLK_PERIOD/2) clk = ~clk;

  task automatic chk(input bit ok, input string req, input string what,
                     input int act, input int exp);
    n_checks++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s %s: actual %0d expected %0d", req, what, act, exp);
    end
  endtask

  function automatic string cls_req(input logic [2:0] c);
    case (c)
      3'd1: return "R4";
      3'd2: return "R5";
      3'd3: return "R6";
      3'd4: return "R7";
      3'd5: return "R8";
      default: return "R3";
    endcase
  endfunction

  task automatic check_idle(input string req);
    chk(id_ready == 1'b1 && busy == 1'b0 && id_hold == 1'b0 && fetch_flush == 1'b0 &&
        redirect == 1'b0 && tgt_enter == 1'b0 && sleep_req == 1'b0, req, "idle outputs",
        {id_ready, busy, id_hold, fetch_flush, redirect, tgt_enter, sleep_req}, 7'b1000000);
  endtask

  task automatic do_reset();
    @(negedge clk);
    rst = 1'b1;
    repeat (3) @(negedge clk);
    rst = 1'b0;
  endtask

  // Present one class and return at the negedge of cycle 1
  task automatic issue(input logic [2:0] c, input logic [1:0] h);
    chk(id_ready == 1'b1, "R2", "ready before request", id_ready, 1);
    id_valid = 1'b1;
    id_class = c;
    pf_hits  = h;
    @(negedge clk);
    id_valid = 1'b0;
  endtask

  task automatic run_vec(input vec_t v);
    int hold_bad = 0, flush_bad = 0, strobe_bad = 0;
    int hh = int'(v.hold);
    int pp = int'(v.pen);
    issue(v.cls, v.hits);
    for (int k = 1; k <= WINDOW; k++) begin
      logic e_hold, e_flush, e_tgt, e_red;
      e_hold  = (k <= hh);
      e_flush = (k > hh) && (k <= hh + pp);
      e_tgt   = v.brn && (k == hh + pp + 1);
      e_red   = v.brn && (k == hh + 1);
      if (id_hold != e_hold) hold_bad++;
      if (fetch_flush != e_flush) flush_bad++;
      if (tgt_enter != e_tgt || redirect != e_red) strobe_bad++;
      @(negedge clk);
    end
    chk(hold_bad == 0, cls_req(v.cls), $sformatf("hold cycles cls%0d hits%0d", v.cls, v.hits),
        hold_bad, 0);
    chk(flush_bad == 0, cls_req(v.cls), $sformatf("flush cycles cls%0d hits%0d", v.cls, v.hits),
        flush_bad, 0);
    chk(strobe_bad == 0, "R11", $sformatf("redirect/target cls%0d hits%0d", v.cls, v.hits),
        strobe_bad, 0);
  endtask

  initial begin
    repeat (5000) @(posedge clk);
    if (!done) begin
      n_checks++;
      n_fail++;
      $display("FAIL watchdog: actual 1 expected 0");
      $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
      $finish;
    end
  end

  initial begin
    do_reset();
    check_idle("R1");

    for (int i = 0; i < NVEC; i++) run_vec(TBL[i]);

    // R9: sleep after two issue cycles, held until wake
    issue(3'd6, 2'd0);
    chk(id_hold == 1'b1 && sleep_req == 1'b0, "R9", "cycle1 hold no sleep",
        {id_hold, sleep_req}, 2'b10);
    @(negedge clk);
    chk(sleep_req == 1'b1 && id_hold == 1'b0, "R9", "cycle2 sleep_req",
        {id_hold, sleep_req}, 2'b01);
    repeat (6) @(negedge clk);
    chk(sleep_req == 1'b1 && id_ready == 1'b0, "R9", "sleep held",
        {sleep_req, id_ready}, 2'b10);
    wake = 1'b1;
    @(negedge clk);
    wake = 1'b0;
    chk(sleep_req == 1'b0 && busy == 1'b0 && id_ready == 1'b1, "R9", "wake returns idle",
        {sleep_req, busy, id_ready}, 3'b001);

    // R10: wake during a trap changes nothing
    begin
      int tgt_at = 0;
      issue(3'd5, 2'd0);
      for (int k = 1; k <= WINDOW; k++) begin
        wake = (k == 3) || (k == 13);
        if (tgt_enter && tgt_at == 0) tgt_at = k;
        @(negedge clk);
      end
      wake = 1'b0;
      chk(tgt_at == 15, "R10", "trap target cycle with wake pulses", tgt_at, 15);
    end

    // R2: request held valid while busy is not taken early
    begin
      int tgt_at = 0;
      issue(3'd2, 2'd0);
      id_valid = 1'b1;
      id_class = 3'd5;
      for (int k = 1; k <= 5; k++) begin
        if (tgt_enter && tgt_at == 0) tgt_at = k;
        if (k < 5) @(negedge clk);
      end
      chk(tgt_at == 5, "R2", "jump target with valid held", tgt_at, 5);
      @(negedge clk);
      id_valid = 1'b0;
      chk(id_hold == 1'b1, "R2", "waiting class taken once ready", id_hold, 1);
    end

    // R1: reset in the middle of a sequence
    repeat (2) @(negedge clk);
    do_reset();
    check_idle("R1");

    // R3: plain class leaves ready high on the next cycle
    issue(3'd0, 2'd3);
    chk(id_ready == 1'b1 && busy == 1'b0, "R3", "plain class no busy",
        {id_ready, busy}, 2'b10);

    done = 1'b1;
    $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
    $finish;
  end

endmodule